// File: doc/BRIEF.md
# Undervoltage chip-enable gate

This block sits in the chip-enable path of a battery-backed static RAM, between the active-low enable that the processor drives and the enable pin of the memory. While the supervisor raises no reset request, the processor's enable reaches the memory unchanged. While a reset request is present, the path is cut and the memory sees its inactive (high) level. A pull-up indication tells the pad logic when the output must be held high by the block instead of following the processor.

A write can already be in progress when the reset request arrives. In that case the block keeps the enable low for a bounded grace window. The window ends early when the processor releases the enable. Once the window has ended, for either reason, the gate stays shut for the rest of the reset request, which includes the supervisor's recovery time. The grace window is a parameter counted in clock cycles. The reset request and the processor enable are taken to be synchronous to the block clock.

Top module: `uv_ce_gate`

## Requirements
- R1: While `rst_n` is low, `ce_out_n` is 1 and `pullup_en` is 1. The gate leaves this shut state only through R8.
- R2: While the gate is open, `ce_out_n` equals `ce_in_n` in the same cycle. This covers every cycle after the gate has opened up to and including the first cycle in which `sup_rst` is high.
- R3: If `ce_in_n` is 1 in the first cycle that `sup_rst` is high, `ce_out_n` is 1 in that cycle and stays 1 for as long as `sup_rst` stays high.
- R4: If `ce_in_n` is 0 in the first cycle that `sup_rst` is high, `ce_out_n` stays 0 for each following cycle in which `ce_in_n` is still 0. This lasts at most GRACE_CYCLES cycles in total, counting that first cycle.
- R5: If `ce_in_n` rises to 1 during the grace window, `ce_out_n` is 1 from that cycle on until `sup_rst` falls, even if `ce_in_n` returns to 0.
- R6: If `ce_in_n` is still 0 after GRACE_CYCLES cycles of the window, `ce_out_n` goes to 1 in the next cycle and stays 1 until `sup_rst` falls.
- R7: While the gate is shut and `sup_rst` is high, no pattern on `ce_in_n` changes `ce_out_n` from 1.
- R8: The first cycle in which `sup_rst` is low still shows the shut state (`ce_out_n` = 1). From the cycle after that, provided `sup_rst` is still low, the output follows `ce_in_n` again. If `sup_rst` falls during the grace window, the gate reopens in the same way.
- R9: `pullup_en` is 0 in every cycle in which `ce_out_n` is driven from `ce_in_n`, and 1 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sup_rst | input | 1 | Reset request from the supervisor, active high, synchronous |
| ce_in_n | input | 1 | Processor chip enable, active low |
| ce_out_n | output | 1 | Gated chip enable to the static RAM, active low |
| pullup_en | output | 1 | High while the output is held inactive rather than passed through |

## Verification
Two functions can act in the same cycle: the grace countdown and the release of the reset request. The most delicate collisions are a reset request that falls while the grace window is still counting, and a processor enable that rises in the very cycle the window runs out. The bench provokes both on purpose. It also drops `ce_in_n` in the first cycle of a reset request. For each of these cases it compares the output, cycle by cycle, against a behavioural model written from the requirements. It also counts the exact number of low output cycles that a long held write receives, and expects GRACE_CYCLES.

// File: rtl/uv_ce_gate_pkg.sv
package uv_ce_gate_pkg;

  typedef enum logic [1:0] {
    GS_OPEN  = 2'd0,
    GS_GRACE = 2'd1,
    GS_SHUT  = 2'd2
  } gate_state_t;

  // True when the cycle now being granted is the last one the window allows.
  // 'given' counts the low cycles already granted before this one.
  function automatic logic grace_last(input int unsigned given,
                                      input int unsigned limit);
    return (given + 32'd1) >= limit;
  endfunction

  // Output selection: drive from the processor, or hold inactive.
  function automatic logic gated_level(input logic pass, input logic ce_n);
    return pass ? ce_n : 1'b1;
  endfunction

endpackage

// File: rtl/uv_ce_grace_timer.sv
module uv_ce_grace_timer #(
  parameter int unsigned GRACE_CYCLES = 1500,
  localparam int unsigned CW = $clog2(GRACE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expire
);
  import uv_ce_gate_pkg::*;

  localparam logic [CW-1:0] LOAD_VAL = CW'(1);
  localparam logic [CW-1:0] TOP_VAL  = CW'(GRACE_CYCLES);

  logic [CW-1:0] given_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      given_q <= '0;
    end else if (load) begin
      given_q <= LOAD_VAL;
    end else if (run && given_q != TOP_VAL) begin
      given_q <= given_q + CW'(1);
    end
  end

  assign expire = grace_last(32'(given_q), GRACE_CYCLES);

endmodule

// File: rtl/uv_ce_gate_fsm.sv
module uv_ce_gate_fsm #(
  parameter int unsigned GRACE_CYCLES = 1500
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sup_rst,
  input  logic                          ce_in_n,
  input  logic                          expire,
  output uv_ce_gate_pkg::gate_state_t   state,
  output logic                          grace_load,
  output logic                          grace_run
);
  import uv_ce_gate_pkg::*;

  // A window of one cycle is used up by the entry cycle itself.
  localparam logic ENTRY_LAST = (GRACE_CYCLES <= 1);

  gate_state_t state_q, state_d;

  always_comb begin
    state_d    = state_q;
    grace_load = 1'b0;
    unique case (state_q)
      GS_OPEN: begin
        if (sup_rst) begin
          if (!ce_in_n && !ENTRY_LAST) begin
            state_d    = GS_GRACE;
            grace_load = 1'b1;
          end else begin
            state_d = GS_SHUT;
          end
        end
      end
      GS_GRACE: begin
        if (!sup_rst) begin
          state_d = GS_OPEN;
        end else if (ce_in_n || expire) begin
          state_d = GS_SHUT;
        end
      end
      GS_SHUT: begin
        if (!sup_rst) begin
          state_d = GS_OPEN;
        end
      end
      default: state_d = GS_SHUT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_SHUT;
    end else begin
      state_q <= state_d;
    end
  end

  assign state     = state_q;
  assign grace_run = (state_q == GS_GRACE);

endmodule

// File: rtl/uv_ce_out_stage.sv
module uv_ce_out_stage (
  input  uv_ce_gate_pkg::gate_state_t state,
  input  logic                        ce_in_n,
  output logic                        pass,
  output logic                        ce_out_n,
  output logic                        pullup_en
);
  import uv_ce_gate_pkg::*;

  always_comb begin
    pass      = (state == GS_OPEN) || (state == GS_GRACE && !ce_in_n);
    ce_out_n  = gated_level(pass, ce_in_n);
    pullup_en = !pass;
  end

endmodule

// File: rtl/uv_ce_gate.sv
module uv_ce_gate #(
  parameter int unsigned GRACE_CYCLES = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_rst,
  input  logic ce_in_n,
  output logic ce_out_n,
  output logic pullup_en
);
  import uv_ce_gate_pkg::*;

  gate_state_t state;
  logic        grace_load;
  logic        grace_run;
  logic        grace_expire;
  logic        gate_pass;

  generate
    if (GRACE_CYCLES > 1) begin : g_timer
      uv_ce_grace_timer #(.GRACE_CYCLES(GRACE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (grace_load),
        .run    (grace_run),
        .expire (grace_expire)
      );
    end else begin : g_no_timer
      assign grace_expire = 1'b1;
    end
  endgenerate

  uv_ce_gate_fsm #(.GRACE_CYCLES(GRACE_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sup_rst    (sup_rst),
    .ce_in_n    (ce_in_n),
    .expire     (grace_expire),
    .state      (state),
    .grace_load (grace_load),
    .grace_run  (grace_run)
  );

  uv_ce_out_stage u_out (
    .state     (state),
    .ce_in_n   (ce_in_n),
    .pass      (gate_pass),
    .ce_out_n  (ce_out_n),
    .pullup_en (pullup_en)
  );

endmodule

// File: rtl/uv_ce_gate_chk.sv
module uv_ce_gate_chk #(
  parameter int unsigned GRACE_CYCLES = 1500
) (
  input logic clk,
  input logic rst_n,
  input logic sup_rst,
  input logic ce_in_n,
  input logic ce_out_n,
  input logic pullup_en,
  input logic gate_pass
);
  logic        seen_q;
  int unsigned low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      low_run_q <= 0;
    end else begin
      seen_q    <= 1'b1;
      low_run_q <= (sup_rst && !ce_out_n) ? low_run_q + 1 : 0;
    end
  end

  // R1: power-on reset leaves the output inactive with the pull-up on
  always @(negedge clk) begin
    if (!rst_n) begin
      p_por_shut_r1: assert (ce_out_n && pullup_en);
    end
  end

  p_idle_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !sup_rst && $past(!sup_rst) && $past(gate_pass)) |-> (ce_out_n == ce_in_n));

  p_high_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $rose(sup_rst) && ce_in_n && $past(gate_pass)) |-> ce_out_n);

  p_stay_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && sup_rst && $past(sup_rst) && $past(ce_out_n)) |-> ce_out_n);

  p_grace_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_rst && !ce_out_n) |-> (low_run_q < GRACE_CYCLES));

  p_reopen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !sup_rst && $past(sup_rst)) |=> (sup_rst || ce_out_n == ce_in_n));

  p_pullup_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_out_n) |-> !pullup_en);

  p_pullup_shut_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && sup_rst && $past(sup_rst) && ce_out_n) |-> pullup_en);

endmodule

bind uv_ce_gate uv_ce_gate_chk #(.GRACE_CYCLES(GRACE_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sup_rst   (sup_rst),
  .ce_in_n   (ce_in_n),
  .ce_out_n  (ce_out_n),
  .pullup_en (pullup_en),
  .gate_pass (gate_pass)
);

// File: tb/uv_ce_gate_tb.sv
module uv_ce_gate_tb;
  localparam int unsigned G = 1500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_rst = 1'b0;
  logic ce_in_n = 1'b0;
  logic ce_out_n;
  logic pullup_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model: 0 open, 1 grace, 2 shut
  int mst = 2;
  int mgiven = 0;
  logic last_out;

  always #5 clk = ~clk;

  uv_ce_gate #(.GRACE_CYCLES(G)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sup_rst   (sup_rst),
    .ce_in_n   (ce_in_n),
    .ce_out_n  (ce_out_n),
    .pullup_en (pullup_en)
  );

  function automatic bit exp_pass(input bit c);
    return (mst == 0) || (mst == 1 && !c);
  endfunction

  function automatic bit exp_out(input bit c);
    return exp_pass(c) ? c : 1'b1;
  endfunction

  task automatic model_step(input bit s, input bit c);
    case (mst)
      0: if (s) begin
           if (!c && G > 1) begin mst = 1; mgiven = 1; end
           else mst = 2;
         end
      1: if (!s) mst = 0;
         else if (c || (mgiven + 1) >= G) mst = 2;
         else mgiven++;
      default: if (!s) mst = 0;
    endcase
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at falling edge, sample, then let the rising edge pass.
  task automatic cyc(input bit s, input bit c, input string req);
    sup_rst = s;
    ce_in_n = c;
    #2;
    last_out = ce_out_n;
    check1({req, " out"}, ce_out_n, exp_out(c));
    check1("R9 pullup", pullup_en, !exp_pass(c));
    @(posedge clk);
    model_step(s, c);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    int lows;
    void'($urandom(32'd1234));
    // R1: inside power-on reset
    @(negedge clk);
    ce_in_n = 1'b0;
    sup_rst = 1'b0;
    #2;
    check1("R1 out", ce_out_n, 1'b1);
    check1("R1 pullup", pullup_en, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    mst = 2;
    // First cycle after release is still shut (R8), then opens
    cyc(0, 0, "R8");
    for (int i = 0; i < 12; i++) cyc(0, i[0], "R2");
    // R3: reset request arrives with enable high; R7 toggling ignored
    cyc(1, 1, "R3");
    for (int i = 0; i < 20; i++) cyc(1, i[1], "R7");
    // R8: release, one shut cycle, then pass again
    cyc(0, 0, "R8");
    check1("R8 first low cycle shut", last_out, 1'b1);
    cyc(0, 0, "R8");
    check1("R8 reopened", last_out, 1'b0);
    cyc(0, 1, "R2");
    // R4/R5: write in flight, released early, then low again ignored
    cyc(1, 0, "R4");
    for (int i = 0; i < 9; i++) cyc(1, 0, "R4");
    cyc(1, 1, "R5");
    for (int i = 0; i < 10; i++) cyc(1, 0, "R5");
    check1("R5 stays high", last_out, 1'b1);
    cyc(0, 1, "R8");
    cyc(0, 1, "R2");
    // R6: held write gets exactly G low cycles
    lows = 0;
    for (int i = 0; i < G + 40; i++) begin
      cyc(1, 0, "R6");
      if (last_out == 1'b0) lows++;
    end
    check1("R6 low count matches", (lows == G), 1'b1);
    if (lows != G) $display("FAIL R6 lows actual=%0d expected=%0d", lows, G);
    // Rise in the very cycle the window ends
    cyc(0, 1, "R8");
    cyc(0, 1, "R2");
    for (int i = 0; i < G - 1; i++) cyc(1, 0, "R4");
    cyc(1, 1, "R5");
    cyc(1, 0, "R5");
    // Release during grace: gate reopens
    cyc(0, 1, "R8");
    cyc(0, 1, "R2");
    for (int i = 0; i < 5; i++) cyc(1, 0, "R4");
    cyc(0, 0, "R8");
    cyc(0, 0, "R2");
    check1("R8 reopen after grace", last_out, 1'b0);
    // Constrained random: reset bursts and short writes
    begin
      bit s = 1'b0;
      bit c = 1'b1;
      for (int i = 0; i < 6000; i++) begin
        if ($urandom_range(0, 29) == 0) s = ~s;
        if ($urandom_range(0, 3) == 0) c = ~c;
        cyc(s, c, "R2 R4 R7 random");
      end
    end
    finish_run();
  end

endmodule